// File: doc/BRIEF.md
# Write-Only I2C Control Slave for a Three-Bank LED Driver

This block is the serial control front end of a charge-pump LED driver. It watches an I2C-compatible two-wire bus, resampled on a fast system clock. It answers one fixed 7-bit device address. It then accepts a register-address byte followed by a single data byte. The data byte lands in one of four sparsely placed control registers: a general-purpose enable register and three bank brightness registers. The contents of all four registers appear in parallel at the outputs. Five enable strobes are also taken from the general-purpose register. These outputs feed the current-sink and gain-control logic that sits next to this block.

The bus state machine moves through these states:

- `ST_IDLE` is the waiting state.
- `ST_ADDR` shifts in the device address.
- `ST_ADDR_ACK` acknowledges the address.
- `ST_REG` shifts in the register pointer.
- `ST_REG_ACK` acknowledges the pointer.
- `ST_DATA` shifts in the data byte.
- `ST_DATA_ACK` acknowledges the data byte and carries out the write.
- `ST_SKIP` holds the bus released until the next bus condition.

Transitions:

- A START from any state enters `ST_ADDR`, and a STOP from any state enters `ST_IDLE`.
- In `ST_ADDR`, `ST_REG` and `ST_DATA`, the SCL falling edge after the eighth bit ends the byte.
- After `ST_ADDR`, a matching address goes to `ST_ADDR_ACK` and a mismatch goes to `ST_SKIP`. Each of the other two shift states goes to its own acknowledge state.
- At the end of the ninth clock, each acknowledge state moves on:
  - `ST_ADDR_ACK` goes to `ST_REG` for a write and to `ST_SKIP` for a read.
  - `ST_REG_ACK` goes to `ST_DATA`.
  - `ST_DATA_ACK` goes to `ST_SKIP`.

A separate active-low hardware reset pin forces every register back to its power-on value and returns the bus machine to idle. No bus traffic is needed for this.

Top module: `led_i2c_ctl`

## Requirements
- R1: After reset, the registers read general-purpose = 0x20, bank A = 0xE0, bank B = 0xE0, bank C = 0xFC. All five enable outputs are 0 and the SDA pull-down is released.
- R2: The slave detects two bus conditions while SCL is high:
  - A falling SDA is a START. It begins a new address phase, and a repeated START in mid-transfer does the same, abandoning the earlier transfer.
  - A rising SDA is a STOP. It returns the slave to idle, where clocked bytes get no acknowledge.
- R3: Only an address byte carrying 7-bit address 0x36 is acknowledged. The acknowledge is SDA held low during the ninth SCL high phase. After any other address the slave leaves SDA released until the next START or STOP.
- R4: An address byte with the direction bit (bit 0) set to 1 is acknowledged. The slave then drives nothing on the following byte, gives no further acknowledge and leaves all registers unchanged.
- R5: A write is address byte 0x6C, a register-pointer byte and a data byte. Each of the three bytes is acknowledged, and the data byte updates only the register selected by the pointer.
- R6: The register pointers and writable bits are:
  - Pointer 0x10 selects general-purpose, with bits 4:0 writable.
  - Pointer 0xA0 selects bank A, with bits 4:0 writable.
  - Pointer 0xB0 selects bank B, with bits 4:0 writable.
  - Pointer 0xC0 selects bank C, with bits 1:0 writable.
  - All other bits always hold their power-on values.
- R7: A write whose pointer is any other value is acknowledged in full and changes no register.
- R8: Only the first data byte of a transfer is taken. Any further byte before STOP or START gets no acknowledge and changes nothing.
- R9: While the hardware reset input is low, two things happen within one clock. All registers return to their power-on values and SDA is released. A transfer that was in progress is abandoned.
- R10: The enable outputs follow the general-purpose register:
  - main-bank enable is bit 0.
  - aux-bank enable is bit 1.
  - indicator enable is bit 2.
  - fifth main sink sense enable is bit 3.
  - third aux sink enable is bit 4.
- R11: Bits are sampled on the SCL rising edge, most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low system reset |
| hw_rst_n | input | 1 | Active-low hardware reset pin, sampled on clk |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| gp_reg | output | 8 | General-purpose register contents |
| bank_a_reg | output | 8 | Bank A brightness register |
| bank_b_reg | output | 8 | Bank B brightness register |
| bank_c_reg | output | 8 | Bank C brightness register |
| en_main | output | 1 | Main-bank enable |
| en_aux | output | 1 | Aux-bank enable |
| en_ind | output | 1 | Indicator enable |
| sense5_en | output | 1 | Fifth main sink sense enable |
| drv3_en | output | 1 | Third aux sink enable |

## Verification
The bench builds the block with its defaults: address 0x36 and a two-flop synchroniser. With a bus quarter-period of five system clocks, every synchroniser delay fits inside one SCL phase. This keeps the sweeps affordable.

The sweeps cover the following:
- All 128 write addresses, to check that exactly one is acknowledged.
- 32 data patterns into each mapped register, which together toggle every bit.
- A spread of unmapped pointers.

Directed sequences cover the remaining conditions:
- a read request;
- a trailing extra byte;
- a repeated START;
- a byte clocked after STOP;
- a hardware reset in mid-transfer.

// File: rtl/led_i2c_pkg.sv
package led_i2c_pkg;

    localparam int NREG = 4;
    localparam int DW   = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } bus_st_t;

    // index 0: general purpose, 1: bank A, 2: bank B, 3: bank C
    localparam logic [NREG-1:0][DW-1:0] REG_PTR  = {8'hC0, 8'hB0, 8'hA0, 8'h10};
    localparam logic [NREG-1:0][DW-1:0] REG_INIT = {8'hFC, 8'hE0, 8'hE0, 8'h20};
    localparam logic [NREG-1:0][DW-1:0] REG_MASK = {8'h03, 8'h1F, 8'h1F, 8'h1F};

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_q;
            sda_d <= sda_q;
        end
    end

    assign scl_q     = scl_pipe[STAGES-1];
    assign sda_q     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_q & ~scl_d;
    assign scl_fall  = ~scl_q & scl_d;
    assign start_det = scl_q & scl_d & sda_d & ~sda_q;
    assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;

endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
    import led_i2c_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR = 7'h36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hw_rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_q,
    input  logic          start_det,
    input  logic          stop_det,
    output logic          sda_oe,
    output logic          wr_stb,
    output logic [DW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    localparam int CNT_W = $clog2(DW + 1);

    bus_st_t          state;
    bus_st_t          nxt;
    logic [CNT_W-1:0] bit_cnt;
    logic [DW-1:0]    shreg;
    logic [DW-1:0]    reg_ptr;
    logic             byte_end;
    logic             shifting;

    assign shifting = (state == ST_ADDR) || (state == ST_REG) || (state == ST_DATA);
    assign byte_end = scl_fall && (bit_cnt == CNT_W'(DW));

    // next-state decision
    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = ST_ADDR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_end)
                                 nxt = (shreg[DW-1:1] == SLV_ADDR) ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall)
                                 nxt = shreg[0] ? ST_SKIP : ST_REG;
                ST_REG:      if (byte_end) nxt = ST_REG_ACK;
                ST_REG_ACK:  if (scl_fall) nxt = ST_DATA;
                ST_DATA:     if (byte_end) nxt = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) nxt = ST_SKIP;
                ST_SKIP:     nxt = ST_SKIP;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            reg_ptr <= '0;
        end else if (!hw_rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            reg_ptr <= '0;
        end else begin
            state <= nxt;
            if (start_det || (nxt != state)) begin
                bit_cnt <= '0;
            end else if (shifting && scl_rise) begin
                bit_cnt <= bit_cnt + 1'b1;
                shreg   <= {shreg[DW-2:0], sda_q};
            end
            if ((state == ST_REG) && (nxt == ST_REG_ACK)) begin
                reg_ptr <= shreg;
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe  = (state == ST_ADDR_ACK) || (state == ST_REG_ACK) || (state == ST_DATA_ACK);
        wr_stb  = (state == ST_DATA) && (nxt == ST_DATA_ACK);
        wr_addr = reg_ptr;
        wr_data = shreg;
    end

endmodule

// File: rtl/led_reg_bank.sv
module led_reg_bank
    import led_i2c_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hw_rst_n,
    input  logic                     wr_stb,
    input  logic [DW-1:0]            wr_addr,
    input  logic [DW-1:0]            wr_data,
    output logic [NREG-1:0][DW-1:0]  regs
);
    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            logic hit;
            assign hit = wr_stb && (wr_addr == REG_PTR[g]);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs[g] <= REG_INIT[g];
                end else if (!hw_rst_n) begin
                    regs[g] <= REG_INIT[g];
                end else if (hit) begin
                    regs[g] <= (REG_INIT[g] & ~REG_MASK[g]) | (wr_data & REG_MASK[g]);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/led_i2c_ctl.sv
module led_i2c_ctl
    import led_i2c_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR    = 7'h36,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] gp_reg,
    output logic [7:0] bank_a_reg,
    output logic [7:0] bank_b_reg,
    output logic [7:0] bank_c_reg,
    output logic       en_main,
    output logic       en_aux,
    output logic       en_ind,
    output logic       sense5_en,
    output logic       drv3_en
);
    logic                    scl_q;
    logic                    sda_q;
    logic                    scl_rise;
    logic                    scl_fall;
    logic                    start_det;
    logic                    stop_det;
    logic                    wr_stb;
    logic [DW-1:0]           wr_addr;
    logic [DW-1:0]           wr_data;
    logic [NREG-1:0][DW-1:0] regs;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_q     (scl_q),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_wr_fsm #(.SLV_ADDR(SLV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_rst_n  (hw_rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_q     (sda_q),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_oe    (sda_oe),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    led_reg_bank u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_rst_n (hw_rst_n),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .regs     (regs)
    );

    assign gp_reg     = regs[0];
    assign bank_a_reg = regs[1];
    assign bank_b_reg = regs[2];
    assign bank_c_reg = regs[3];

    assign en_main   = regs[0][0];
    assign en_aux    = regs[0][1];
    assign en_ind    = regs[0][2];
    assign sense5_en = regs[0][3];
    assign drv3_en   = regs[0][4];

endmodule

// File: rtl/led_i2c_chk.sv
module led_i2c_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hw_rst_n,
    input logic       sda_oe,
    input logic       scl_q,
    input logic       wr_stb,
    input logic [7:0] gp,
    input logic [7:0] ra,
    input logic [7:0] rb,
    input logic [7:0] rc,
    input logic [4:0] ens
);
    AST_HWRST_SDA_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_rst_n |=> !sda_oe); // R9

    AST_HWRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_rst_n |=> (gp == 8'h20 && ra == 8'hE0 && rb == 8'hE0 && rc == 8'hFC)); // R9

    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (gp[7:5] == 3'b001 && ra[7:5] == 3'b111 && rb[7:5] == 3'b111 && rc[7:2] == 6'h3F)); // R6

    AST_CHANGE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({gp, ra, rb, rc}) |-> ($past(wr_stb) || !$past(hw_rst_n))); // R5

    AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_q); // R3

    AST_ENABLES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_rst_n |=> (ens == 5'b0)); // R10

endmodule

bind led_i2c_ctl led_i2c_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_rst_n (hw_rst_n),
    .sda_oe   (sda_oe),
    .scl_q    (scl_q),
    .wr_stb   (wr_stb),
    .gp       (gp_reg),
    .ra       (bank_a_reg),
    .rb       (bank_b_reg),
    .rc       (bank_c_reg),
    .ens      ({drv3_en, sense5_en, en_ind, en_aux, en_main})
);

// File: tb/sim_led_i2c_ctl.sv
`timescale 1ns/1ps
module sim_led_i2c_ctl;

    localparam int Q = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hw_rst_n = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [7:0] gp_reg, bank_a_reg, bank_b_reg, bank_c_reg;
    logic en_main, en_aux, en_ind, sense5_en, drv3_en;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    logic [7:0] mdl [4];
    logic [7:0] ptr_of  [4] = '{8'h10, 8'hA0, 8'hB0, 8'hC0};
    logic [7:0] init_of [4] = '{8'h20, 8'hE0, 8'hE0, 8'hFC};
    logic [7:0] mask_of [4] = '{8'h1F, 8'h1F, 8'h1F, 8'h03};

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    led_i2c_ctl u0 (
        .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n),
        .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .gp_reg(gp_reg), .bank_a_reg(bank_a_reg), .bank_b_reg(bank_b_reg), .bank_c_reg(bank_c_reg),
        .en_main(en_main), .en_aux(en_aux), .en_ind(en_ind), .sense5_en(sense5_en), .drv3_en(drv3_en)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        scl = 1'b0; wait_q(1);
        sda_m = 1'b1; wait_q(1);
        scl = 1'b1; wait_q(2);
        sda_m = 1'b0; wait_q(2);
        scl = 1'b0; wait_q(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(1);
        scl = 1'b1; wait_q(2);
        sda_m = 1'b1; wait_q(2);
    endtask

    task automatic bus_bit(input logic b, output logic seen);
        sda_m = b; wait_q(1);
        scl = 1'b1; wait_q(1);
        seen = sda_line;
        wait_q(1);
        scl = 1'b0; wait_q(1);
    endtask

    // returns 1 when acknowledged; lows counts data-phase low samples
    task automatic bus_byte(input logic [7:0] v, output logic ack, output int lows);
        logic s;
        lows = 0;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(v[i], s);
            if (v[i] && !s) lows++;
        end
        bus_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic check_regs(input string tag);
        check({tag, " gp"}, gp_reg, mdl[0]);
        check({tag, " A"},  bank_a_reg, mdl[1]);
        check({tag, " B"},  bank_b_reg, mdl[2]);
        check({tag, " C"},  bank_c_reg, mdl[3]);
    endtask

    task automatic write_reg(input logic [7:0] ptr, input logic [7:0] d, output logic [2:0] acks);
        int l;
        bus_start();
        bus_byte(8'h6C, acks[2], l);
        bus_byte(ptr, acks[1], l);
        bus_byte(d, acks[0], l);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [2:0] acks;
        logic a1, a2;
        int l;
        for (int k = 0; k < 4; k++) mdl[k] = init_of[k];
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state, R10 enables off
        check_regs("R1 reset");
        check("R1 sda released", sda_oe, 1'b0);
        check("R10 enables at reset", {drv3_en, sense5_en, en_ind, en_aux, en_main}, 5'b0);

        // R3 address sweep: only 0x36 with write bit is acknowledged
        for (int a = 0; a < 128; a++) begin
            bus_start();
            bus_byte({a[6:0], 1'b0}, a1, l);
            check("R3 address ack", a1, (a == 'h36));
            if (a != 'h36) begin
                bus_byte(8'hA0, a2, l);
                check("R3 ignored after mismatch", a2, 1'b0);
            end
            bus_stop();
        end
        check_regs("R3 no change");

        // R5 R6 R10 R11 data sweep over every mapped register
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < 32; i++) begin
                logic [7:0] d;
                d = 8'((i << 3) | (i & 7));
                write_reg(ptr_of[r], d, acks);
                mdl[r] = (init_of[r] & ~mask_of[r]) | (d & mask_of[r]);
                check("R5 three acks", acks, 3'b111);
                check_regs("R6 R11 masked write");
                if (r == 0)
                    check("R10 enable map", {drv3_en, sense5_en, en_ind, en_aux, en_main}, mdl[0][4:0]);
            end
        end

        // R7 unmapped pointers
        for (int k = 0; k < 20; k++) begin
            logic [7:0] p;
            p = (k < 16) ? 8'(k * 16 + 5) : ((k == 16) ? 8'h11 : (k == 17) ? 8'hA1 : (k == 18) ? 8'h00 : 8'hFF);
            write_reg(p, 8'h5A, acks);
            check("R7 unmapped acked", acks, 3'b111);
            check_regs("R7 unmapped no change");
        end

        // R4 read request
        bus_start();
        bus_byte(8'h6D, a1, l);
        check("R4 read address acked", a1, 1'b1);
        bus_byte(8'hFF, a2, l);
        check("R4 no data driven", l, 0);
        check("R4 no ack after read", a2, 1'b0);
        bus_stop();
        check_regs("R4 no change");

        // R8 extra byte ignored
        bus_start();
        bus_byte(8'h6C, a1, l);
        bus_byte(8'hA0, a1, l);
        bus_byte(8'h0B, a1, l);
        bus_byte(8'h15, a2, l);
        bus_stop();
        mdl[1] = 8'hEB;
        check("R8 extra byte not acked", a2, 1'b0);
        check_regs("R8 first data kept");

        // R2 repeated START abandons earlier transfer
        bus_start();
        bus_byte(8'h6C, a1, l);
        bus_byte(8'hB0, a1, l);
        bus_start();
        bus_byte(8'h6C, a1, l);
        check("R2 repeated start address ack", a1, 1'b1);
        bus_byte(8'hA0, a1, l);
        bus_byte(8'h13, a1, l);
        bus_stop();
        mdl[1] = 8'hF3;
        check_regs("R2 repeated start");

        // R2 byte after STOP without START is ignored
        bus_start();
        bus_byte(8'h6C, a1, l);
        bus_byte(8'hC0, a1, l);
        bus_stop();
        scl = 1'b0; wait_q(1);
        bus_byte(8'h01, a2, l);
        scl = 1'b1; sda_m = 1'b1; wait_q(2);
        check("R2 no ack after stop", a2, 1'b0);
        check_regs("R2 after stop");

        // R9 hardware reset restores power-on values
        write_reg(8'h10, 8'h1F, acks);
        mdl[0] = 8'h3F;
        check_regs("R9 before reset");
        hw_rst_n = 1'b0;
        repeat (4) @(negedge clk);
        hw_rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 4; k++) mdl[k] = init_of[k];
        check_regs("R9 after reset");
        check("R9 enables off", {drv3_en, sense5_en, en_ind, en_aux, en_main}, 5'b0);

        // R9 reset mid-transfer abandons it
        write_reg(8'hA0, 8'h07, acks);
        mdl[1] = 8'hE7;
        bus_start();
        bus_byte(8'h6C, a1, l);
        bus_byte(8'hA0, a1, l);
        hw_rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 sda released in reset", sda_oe, 1'b0);
        hw_rst_n = 1'b1;
        repeat (2) @(negedge clk);
        bus_byte(8'h1C, a2, l);
        bus_stop();
        mdl[1] = 8'hE0;
        check("R9 aborted transfer not acked", a2, 1'b0);
        check_regs("R9 mid-transfer");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule